// File: doc/BRIEF.md
# On-the-fly SPI channel selector

This block sits behind the serial port of a multiplexed converter and lets the host steer the input multiplexer from inside ordinary data frames. It watches chip select, the serial clock and the serial data line, collects each frame MSB first, and when frame end arrives decides whether the frame was a channel pick or something for the regular command decoder. The host turns the feature on with two register writes: a 2-bit sequencing field set to 01b and a separate enable bit set to 1. While both hold, any 16-bit frame whose first bit is 1 names the channel for the next conversion in its following four bits, and the rest of that frame is ignored.

Channel numbers above the physical input count fall back to input 0 and raise a sticky error flag. A one-register tag pipeline reports which channel the data returned in the coming frame was converted from. A freshly picked channel therefore shows up in the returned data two frames after the pick. Frames of any other kind, and every frame while the feature is off, are handed to the downstream decoder through a one-cycle valid pulse.

The serial pins are sampled in the system clock domain. The design assumes they are already synchronous and that the serial clock runs at no more than half the system clock rate.

Top module: `otf_chan_sel`

## Requirements
- R1: After reset, `chan` and `data_chan` are 0, `err` is 0, `otf_active` is 0 and `frame_valid` is 0.
- R2: A 24-bit frame with first byte 0x08 (write), second byte an address and third byte the data is a register write. Address 0x1C loads data bits [1:0] into the sequencing field. Address 0x2A loads data bit 0 into the enable bit. `otf_active` is 1 only while the field is 01b and the enable bit is 1.
- R3: With `otf_active` high, a 16-bit frame whose bit 15 (the first bit sent) is 1 and whose bits [14:11] hold an ID from 0 to 7 loads that ID into `chan`. The load happens when chip select rises, bits [10:0] have no effect, and no `frame_valid` is produced.
- R4: With `otf_active` high, a select frame carrying an ID from 8 to 15 loads 0 into `chan` and sets `err`.
- R5: `err` stays set across later frames until `err_clr` is high for a clock cycle. If an error is set in the same cycle, the set wins.
- R6: A 16-bit frame with bit 15 at 0, including the all-zero NOP, leaves `chan` unchanged. It produces `frame_valid` with `frame_word` equal to the 16 bits zero-extended and `frame_wide` at 0.
- R7: While `otf_active` is low, `chan` never changes. Every complete 16-bit frame, whatever its first bit, is passed on through `frame_valid`.
- R8: A frame whose bit count at chip-select rise is neither 16 nor 24 is discarded. It produces no `frame_valid`, and `chan`, `err` and `data_chan` stay unchanged.
- R9: At the end of each 16-bit frame, `data_chan` takes the value `chan` held during that frame. After a select frame, `data_chan` therefore shows the new channel once the next 16-bit frame has ended.
- R10: Every 24-bit frame, including the register writes of R2, is passed on with `frame_valid`, `frame_wide` at 1 and `frame_word` holding the 24 bits.
- R11: `frame_valid` is a single-cycle pulse in the cycle after chip select is seen rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| err_clr | input | 1 | Clears the sticky error flag |
| chan | output | 3 | Channel selected for the next conversion |
| data_chan | output | 3 | Channel the data returned in the coming frame was taken from |
| err | output | 1 | Sticky out-of-range channel flag |
| otf_active | output | 1 | On-the-fly selection is enabled |
| frame_valid | output | 1 | One-cycle pulse: a frame is handed to the command decoder |
| frame_word | output | 24 | Frame contents, zero-extended for 16-bit frames |
| frame_wide | output | 1 | The handed-on frame was 24 bits long |

## Verification
The bench goes after the half-enabled configuration. A design that tests only one of the two enable conditions would start switching channels after the first write. It sends select frames whose don't-care bits are all ones, which would corrupt the ID in a design with an off-by-one field slice. It also sends 15- and 17-bit frames, which a design without a strict length check would treat as selects. Finally, it follows the tag pipeline across a run of selects and NOPs, which exposes a tag that lags by the wrong number of frames, an error flag that clears itself on the next good ID, and a select that leaks through to the command decoder.

// File: rtl/otf_chan_sel.sv
module otf_chan_sel #(
  parameter int          DATA_BITS = 16,
  parameter int          REG_BITS  = 24,
  parameter int          CHAN_BITS = 3,
  parameter int          ID_BITS   = 4,
  parameter logic [7:0]  WR_OP     = 8'h08,
  parameter logic [7:0]  SEQ_ADDR  = 8'h1C,
  parameter logic [7:0]  OTF_ADDR  = 8'h2A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdi,
  input  logic                 err_clr,
  output logic [CHAN_BITS-1:0] chan,
  output logic [CHAN_BITS-1:0] data_chan,
  output logic                 err,
  output logic                 otf_active,
  output logic                 frame_valid,
  output logic [REG_BITS-1:0]  frame_word,
  output logic                 frame_wide
);

  localparam int CNT_W   = $clog2(REG_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                cs_q, sclk_q;
  logic [CNT_W-1:0]    cnt;
  logic [REG_BITS-1:0] sh;
  logic [1:0]          seq_mode;
  logic                otf_en;

  wire cs_rise   = cs_n & ~cs_q;
  wire bit_tick  = sclk & ~sclk_q & ~cs_n;
  wire done_data = cs_rise && (cnt == CNT_W'(DATA_BITS));
  wire done_reg  = cs_rise && (cnt == CNT_W'(REG_BITS));

  wire [ID_BITS-1:0] id   = sh[DATA_BITS-2 -: ID_BITS];
  wire               sel  = done_data && otf_active && sh[DATA_BITS-1];
  wire               bad  = (id >> CHAN_BITS) != '0;
  wire               wr   = done_reg && (sh[REG_BITS-1 -: 8] == WR_OP);
  wire [7:0]         addr = sh[15:8];
  wire [7:0]         wdat = sh[7:0];

  assign otf_active = (seq_mode == 2'b01) && otf_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n)
        cnt <= '0;
      else if (bit_tick && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
      if (bit_tick)
        sh <= {sh[REG_BITS-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_mode <= 2'b00;
      otf_en   <= 1'b0;
    end else if (wr) begin
      if (addr == SEQ_ADDR) seq_mode <= wdat[1:0];
      if (addr == OTF_ADDR) otf_en   <= wdat[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan      <= '0;
      data_chan <= '0;
      err       <= 1'b0;
    end else begin
      if (done_data)
        data_chan <= chan;
      if (sel)
        chan <= bad ? '0 : id[CHAN_BITS-1:0];
      err <= (err & ~err_clr) | (sel & bad);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      frame_word  <= '0;
      frame_wide  <= 1'b0;
    end else begin
      frame_valid <= (done_data && !sel) || done_reg;
      if (done_reg) begin
        frame_word <= sh;
        frame_wide <= 1'b1;
      end else if (done_data) begin
        frame_word <= REG_BITS'(sh[DATA_BITS-1:0]);
        frame_wide <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/otf_chan_sel_chk.sv
module otf_chan_sel_chk #(
  parameter int CHAN_BITS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 err_clr,
  input logic [CHAN_BITS-1:0] chan,
  input logic [CHAN_BITS-1:0] data_chan,
  input logic                 err,
  input logic                 otf_active,
  input logic                 frame_valid
);

  // R3
  chan_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan) |-> ($past(cs_n) && !$past(cs_n, 2)));

  // R6
  pass_keeps_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $stable(chan));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(err_clr));

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R9
  tag_follows_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_chan) |-> (data_chan == $past(chan)));

  // R7
  idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !otf_active |=> $stable(chan));

endmodule

bind otf_chan_sel otf_chan_sel_chk #(.CHAN_BITS(CHAN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .err_clr(err_clr),
  .chan(chan), .data_chan(data_chan), .err(err),
  .otf_active(otf_active), .frame_valid(frame_valid)
);

// File: tb/test_otf_chan_sel.sv
`timescale 1ns/1ps
module test_otf_chan_sel;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, err_clr = 1'b0;
  logic [2:0]  chan, data_chan;
  logic        err, otf_active, frame_valid, frame_wide;
  logic [23:0] frame_word;

  int n_chk = 0, n_bad = 0;
  logic fv_a, fv_b, wide_a;
  logic [23:0] word_a;
  bit done = 0;

  always #2 clk = ~clk;

  otf_chan_sel i_otf_chan_sel (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .err_clr(err_clr),
    .chan(chan), .data_chan(data_chan), .err(err), .otf_active(otf_active),
    .frame_valid(frame_valid), .frame_word(frame_word), .frame_wide(frame_wide)
  );

  // {len, word, chan, err, fv, data_chan}
  localparam logic [36:0] VECS [0:10] = '{
    {5'd16, 24'h009800, 3'd3, 1'b0, 1'b0, 3'd0},
    {5'd16, 24'h000000, 3'd3, 1'b0, 1'b1, 3'd3},
    {5'd16, 24'h00B800, 3'd7, 1'b0, 1'b0, 3'd3},
    {5'd16, 24'h00C7FF, 3'd0, 1'b1, 1'b0, 3'd7},
    {5'd16, 24'h008000, 3'd0, 1'b1, 1'b0, 3'd0},
    {5'd16, 24'h008FFF, 3'd1, 1'b1, 1'b0, 3'd0},
    {5'd16, 24'h007FFF, 3'd1, 1'b1, 1'b1, 3'd1},
    {5'd15, 24'h004800, 3'd1, 1'b1, 1'b0, 3'd1},
    {5'd17, 24'h013000, 3'd1, 1'b1, 1'b0, 3'd1},
    {5'd16, 24'h00F800, 3'd0, 1'b1, 1'b0, 3'd1},
    {5'd16, 24'h00A000, 3'd4, 1'b1, 1'b0, 3'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [23:0] w);
    @(negedge clk); cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdi = w[i]; sclk = 1'b0;
      @(negedge clk); sclk = 1'b1;
    end
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); fv_a = frame_valid; word_a = frame_word; wide_a = frame_wide;
    @(negedge clk); fv_b = frame_valid;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 chan", chan, 0);
    check("R1 data_chan", data_chan, 0);
    check("R1 err", err, 0);
    check("R1 otf_active", otf_active, 0);
    check("R1 frame_valid", frame_valid, 0);

    send(16, 24'h009800);
    check("R7 chan held while off", chan, 0);
    check("R7 passed while off", fv_a, 1);
    send(24, 24'h081C01);
    check("R10 write passed", fv_a, 1);
    check("R10 wide", wide_a, 1);
    check("R10 word", word_a, 24'h081C01);
    check("R11 single pulse", fv_b, 0);
    check("R2 field only", otf_active, 0);
    send(16, 24'h009800);
    check("R2 half enabled no switch", chan, 0);
    send(24, 24'h082A01);
    check("R2 active", otf_active, 1);

    foreach (VECS[k]) begin
      logic [36:0] v;
      v = VECS[k];
      send(int'(v[36:32]), v[31:8]);
      check($sformatf("R3/R4/R8 chan vec%0d", k), chan, v[7:5]);
      check($sformatf("R4/R5 err vec%0d", k), err, v[4]);
      check($sformatf("R6/R8 frame_valid vec%0d", k), fv_a, v[3]);
      check($sformatf("R9 data_chan vec%0d", k), data_chan, v[2:0]);
      if (v[3]) begin
        check($sformatf("R6 word vec%0d", k), word_a, v[31:8]);
        check($sformatf("R6 narrow vec%0d", k), wide_a, 0);
      end
    end

    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R5 cleared", err, 0);
    check("R5 chan kept", chan, 4);

    send(24, 24'h123456);
    check("R10 other wide frame", fv_a, 1);
    check("R10 word", word_a, 24'h123456);
    check("R2 non-write no effect", otf_active, 1);

    send(24, 24'h081C00);
    check("R2 field cleared", otf_active, 0);
    send(16, 24'h009000);
    check("R7 no switch", chan, 4);
    check("R7 passed", fv_a, 1);
    check("R6 word", word_a, 24'h009000);

    do_reset();
    check("R1 chan after reset", chan, 0);
    check("R1 otf after reset", otf_active, 0);
    send(16, 24'h00B000);
    check("R1 mode off after reset", chan, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule